// File: doc/BRIEF.md
# Triggerless Frame Hit Buffer

This block sits between the hit-address producers of one pixel readout slice and a single outgoing data link. There is no trigger. Hit addresses arrive whenever they arrive, each tagged with the sub-region it came from. Every hit is written into the memory that belongs to its sub-region. A free-running period counter, advanced by a 40 MHz tick, cuts time into integration frames of 2, 5 or 10 µs. When a frame closes, the block records how many hits each memory received during that frame. A packer then emits one packet for the frame: a header with a frame number, the hits of memory 0, then those of memory 1, then those of memory 2, and a trailer.

The input never stalls. A memory that is full drops any further hits for the frame now being collected, and that frame's trailer carries an incomplete mark. Hits that arrive after a frame boundary stay in the memories behind the closed frame's hits and go into the next packet. A frame with no hits still produces a header and a trailer.

The output is a valid/ready stream. The consumer may hold `pkt_ready` low for any number of cycles. While `pkt_valid` is high and the word has not been taken, the word stays unchanged. Back-pressure on the output never reaches the hit input: when draining falls behind, the memories fill up and hits are dropped.

Top module: `fhb_frame_buffer`

## Requirements
- R1: After reset, `pkt_valid` is low and `hit_ready` is high. `hit_ready` stays high for as long as reset is released.
- R2: A frame closes on the Nth tick counted since the previous boundary. N is 80 for period code 00, 200 for code 01, 400 for code 10, and 80 for the reserved code 11. No packet for the frame starts before that tick.
- R3: Each region memory holds at most 128 hits. A hit for a full memory is dropped and sets bit 17 of the trailer of the frame being collected. The trailer count in bits 8:0 never exceeds 384.
- R4: Each packet word is tagged by `pkt_type`: 00 is the header, 01 a hit, 10 the trailer, and 11 is never used. The header carries the frame number in bits 7:0. A hit word carries the region in bits 17:16 and the address in bits 14:0. The trailer carries the incomplete flag in bit 17 and the count of hits sent in bits 8:0. `pkt_last` is high only on the trailer.
- R5: Frame numbers start at 0 after reset and rise by one per frame, wrapping from 255 to 0.
- R6: Within a packet, all hits of region 0 come first, then those of region 1, then those of region 2. Inside each region, hits keep their arrival order.
- R7: A hit accepted after a frame boundary never appears in the packet of the frame that closed at that boundary.
- R8: A frame with no hits yields a header followed directly by a trailer with count 0 and the incomplete flag clear.
- R9: While `pkt_valid` is high and `pkt_ready` is low, the next cycle keeps `pkt_valid` high with the same `pkt_type` and `pkt_data`.
- R10: A hit with a region index of 3 or above is discarded. It appears in no packet and does not set the incomplete flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_tick | input | 1 | 40 MHz time-base tick, one cycle wide |
| period_sel | input | 2 | Integration period code |
| hit_valid | input | 1 | Hit word present |
| hit_ready | output | 1 | Hit input accepts a word (high out of reset) |
| hit_region | input | 2 | Region memory index of the hit |
| hit_addr | input | 15 | Hit pixel address |
| pkt_valid | output | 1 | Packet word present |
| pkt_ready | input | 1 | Consumer takes the packet word |
| pkt_type | output | 2 | Word kind: header, hit or trailer |
| pkt_data | output | 18 | Packet word payload |
| pkt_last | output | 1 | Marks the trailer word |

## Verification
The checker watches four rules on every cycle:
- the output word is held while it is stalled;
- the type code is legal and `pkt_last` appears only with a trailer;
- frame numbers step by one from header to header, and hit regions never go backwards within a packet;
- trailer counts and region indices stay in range.

Which hits land in which packet, the exact drop point at 128 entries, the tick count at which each period code closes a frame, and the handling of empty frames and out-of-range regions can only be shown by the bench. It does this by driving those patterns and comparing every packet word against its own model.

// File: rtl/fhb_pkg.sv
package fhb_pkg;
  typedef enum logic [1:0] {
    PK_HDR = 2'b00,
    PK_HIT = 2'b01,
    PK_TRL = 2'b10
  } pkt_kind_e;

  typedef enum logic [1:0] {
    PS_IDLE,
    PS_HDR,
    PS_HIT,
    PS_TRL
  } pack_state_e;

  typedef enum logic [1:0] {
    SEL_SHORT = 2'b00,
    SEL_MID   = 2'b01,
    SEL_LONG  = 2'b10,
    SEL_RSVD  = 2'b11
  } period_sel_e;
endpackage

// File: rtl/fhb_period_timer.sv
module fhb_period_timer
  import fhb_pkg::*;
#(
  parameter int TICKS_SHORT = 80,
  parameter int TICKS_MID   = 200,
  parameter int TICKS_LONG  = 400,
  localparam int CW = $clog2(TICKS_LONG + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic [1:0] sel_i,
  input  logic       hold_i,
  output logic       boundary_o
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] limit;
  logic          pend_q;
  logic          wrap;
  logic          due;

  // Reserved code falls back to the short period.
  always_comb begin
    case (period_sel_e'(sel_i))
      SEL_MID:  limit = CW'(TICKS_MID - 1);
      SEL_LONG: limit = CW'(TICKS_LONG - 1);
      default:  limit = CW'(TICKS_SHORT - 1);
    endcase
  end

  assign wrap       = tick_i && (cnt_q >= limit);
  assign due        = wrap || pend_q;
  assign boundary_o = due && !hold_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      if (wrap)        cnt_q <= '0;
      else if (tick_i) cnt_q <= cnt_q + 1'b1;
      pend_q <= due && hold_i;
    end
  end
endmodule

// File: rtl/fhb_hit_fifo.sv
module fhb_hit_fifo #(
  parameter int W     = 15,
  parameter int DEPTH = 128,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  input  logic         pop_i,
  output logic [W-1:0] dout_o,
  output logic         full_o,
  output logic         empty_o
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [AW:0]   cnt_q;
  logic          do_push, do_pop;

  assign full_o  = (cnt_q == (AW+1)'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign dout_o  = mem[rd_q];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= din_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= wr_q + 1'b1;
      if (do_pop)  rd_q <= rd_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/fhb_frame_tracker.sv
module fhb_frame_tracker #(
  parameter int N_REG = 3,
  parameter int QW    = 8,
  parameter int FID_W = 8,
  parameter int PEND  = 4,
  localparam int PW = $clog2(PEND)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [N_REG-1:0]           acc_i,
  input  logic                       drop_i,
  input  logic                       boundary_i,
  output logic                       desc_full_o,
  output logic                       desc_valid_o,
  output logic [FID_W-1:0]           desc_fid_o,
  output logic [N_REG-1:0][QW-1:0]   desc_cnt_o,
  output logic                       desc_inc_o,
  input  logic                       desc_pop_i
);
  logic [N_REG-1:0][QW-1:0] cur_q, cur_nx;
  logic                     inc_q, inc_nx;
  logic [FID_W-1:0]         fid_q;

  logic [N_REG-1:0][QW-1:0] q_cnt [PEND];
  logic [FID_W-1:0]         q_fid [PEND];
  logic [PEND-1:0]          q_inc;
  logic [PW-1:0]            wp_q, rp_q;
  logic [PW:0]              occ_q;
  logic                     do_push, do_pop;

  // A hit taken in the boundary cycle still belongs to the closing frame.
  always_comb begin
    for (int r = 0; r < N_REG; r++) cur_nx[r] = cur_q[r] + QW'(acc_i[r]);
    inc_nx = inc_q | drop_i;
  end

  assign desc_full_o  = (occ_q == (PW+1)'(PEND));
  assign desc_valid_o = (occ_q != '0);
  assign desc_fid_o   = q_fid[rp_q];
  assign desc_cnt_o   = q_cnt[rp_q];
  assign desc_inc_o   = q_inc[rp_q];
  assign do_push      = boundary_i && !desc_full_o;
  assign do_pop       = desc_pop_i && desc_valid_o;

  always_ff @(posedge clk) begin
    if (do_push) begin
      q_cnt[wp_q] <= cur_nx;
      q_fid[wp_q] <= fid_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= '0;
      inc_q <= 1'b0;
      fid_q <= '0;
      q_inc <= '0;
      wp_q  <= '0;
      rp_q  <= '0;
      occ_q <= '0;
    end else begin
      if (do_push) begin
        q_inc[wp_q] <= inc_nx;
        wp_q        <= wp_q + 1'b1;
        fid_q       <= fid_q + 1'b1;
        cur_q       <= '0;
        inc_q       <= 1'b0;
      end else begin
        cur_q <= cur_nx;
        inc_q <= inc_nx;
      end
      if (do_pop) rp_q <= rp_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   occ_q <= occ_q + 1'b1;
        2'b01:   occ_q <= occ_q - 1'b1;
        default: occ_q <= occ_q;
      endcase
    end
  end
endmodule

// File: rtl/fhb_packer.sv
module fhb_packer
  import fhb_pkg::*;
#(
  parameter int N_REG  = 3,
  parameter int QW     = 8,
  parameter int FID_W  = 8,
  parameter int ADDR_W = 15,
  parameter int REG_W  = 2,
  parameter int CNT_W  = 9,
  parameter int PKT_W  = 18
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            desc_valid_i,
  input  logic [FID_W-1:0]                desc_fid_i,
  input  logic [N_REG-1:0][QW-1:0]        desc_cnt_i,
  input  logic                            desc_inc_i,
  output logic                            desc_pop_o,
  input  logic [N_REG-1:0][ADDR_W-1:0]    head_i,
  output logic [N_REG-1:0]                pop_o,
  output logic                            pkt_valid_o,
  input  logic                            pkt_ready_i,
  output logic [1:0]                      pkt_type_o,
  output logic [PKT_W-1:0]                pkt_data_o,
  output logic                            pkt_last_o
);
  pack_state_e       state_q;
  logic [REG_W-1:0]  idx_q;
  logic [QW-1:0]     remain_q;
  logic [CNT_W-1:0]  sent_q;
  logic              fire;
  logic              first_ok, next_ok;
  logic [REG_W-1:0]  first_idx, next_idx;

  // Fixed order: lowest non-empty region first, then upward.
  always_comb begin
    first_ok  = 1'b0;
    first_idx = '0;
    next_ok   = 1'b0;
    next_idx  = '0;
    for (int r = N_REG - 1; r >= 0; r--) begin
      if (desc_cnt_i[r] != '0) begin
        first_ok  = 1'b1;
        first_idx = REG_W'(r);
      end
      if (r > int'(idx_q) && desc_cnt_i[r] != '0) begin
        next_ok  = 1'b1;
        next_idx = REG_W'(r);
      end
    end
  end

  assign pkt_valid_o = (state_q != PS_IDLE);
  assign fire        = pkt_valid_o && pkt_ready_i;
  assign pkt_last_o  = (state_q == PS_TRL);
  assign desc_pop_o  = (state_q == PS_TRL) && fire;
  assign pop_o       = (state_q == PS_HIT && fire) ? (N_REG'(1) << idx_q) : '0;

  always_comb begin
    pkt_data_o = '0;
    pkt_type_o = PK_HDR;
    case (state_q)
      PS_HDR: begin
        pkt_type_o            = PK_HDR;
        pkt_data_o[FID_W-1:0] = desc_fid_i;
      end
      PS_HIT: begin
        pkt_type_o                          = PK_HIT;
        pkt_data_o[PKT_W-1 -: REG_W]        = idx_q;
        pkt_data_o[ADDR_W-1:0]              = head_i[idx_q];
      end
      PS_TRL: begin
        pkt_type_o            = PK_TRL;
        pkt_data_o[PKT_W-1]   = desc_inc_i;
        pkt_data_o[CNT_W-1:0] = sent_q;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= PS_IDLE;
      idx_q    <= '0;
      remain_q <= '0;
      sent_q   <= '0;
    end else begin
      case (state_q)
        PS_IDLE: begin
          sent_q <= '0;
          if (desc_valid_i) state_q <= PS_HDR;
        end
        PS_HDR: if (fire) begin
          if (first_ok) begin
            state_q  <= PS_HIT;
            idx_q    <= first_idx;
            remain_q <= desc_cnt_i[first_idx];
          end else begin
            state_q <= PS_TRL;
          end
        end
        PS_HIT: if (fire) begin
          sent_q <= sent_q + 1'b1;
          if (remain_q == QW'(1)) begin
            if (next_ok) begin
              idx_q    <= next_idx;
              remain_q <= desc_cnt_i[next_idx];
            end else begin
              state_q <= PS_TRL;
            end
          end else begin
            remain_q <= remain_q - 1'b1;
          end
        end
        PS_TRL: if (fire) state_q <= PS_IDLE;
        default: state_q <= PS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fhb_frame_buffer.sv
module fhb_frame_buffer
  import fhb_pkg::*;
#(
  parameter int ADDR_W      = 15,
  parameter int DEPTH       = 128,
  parameter int N_REG       = 3,
  parameter int FID_W       = 8,
  parameter int PEND        = 4,
  parameter int TICKS_SHORT = 80,
  parameter int TICKS_MID   = 200,
  parameter int TICKS_LONG  = 400,
  localparam int REG_W = $clog2(N_REG),
  localparam int QW    = $clog2(DEPTH + 1),
  localparam int CNT_W = $clog2(N_REG * DEPTH + 1),
  localparam int PKT_W = REG_W + 1 + ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_tick,
  input  logic [1:0]        period_sel,
  input  logic              hit_valid,
  output logic              hit_ready,
  input  logic [REG_W-1:0]  hit_region,
  input  logic [ADDR_W-1:0] hit_addr,
  output logic              pkt_valid,
  input  logic              pkt_ready,
  output logic [1:0]        pkt_type,
  output logic [PKT_W-1:0]  pkt_data,
  output logic              pkt_last
);
  logic                         boundary, desc_full, desc_valid, desc_inc, desc_pop;
  logic [FID_W-1:0]             desc_fid;
  logic [N_REG-1:0][QW-1:0]     desc_cnt;
  logic [N_REG-1:0]             push, pop, full, empty;
  logic [N_REG-1:0][ADDR_W-1:0] head;
  logic                         take, drop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hit_ready <= 1'b0;
    else        hit_ready <= 1'b1;
  end

  assign take = hit_valid && hit_ready && (int'(hit_region) < N_REG);

  always_comb begin
    drop = 1'b0;
    for (int r = 0; r < N_REG; r++) begin
      push[r] = take && (int'(hit_region) == r) && !full[r];
      drop    = drop | (take && (int'(hit_region) == r) && full[r]);
    end
  end

  fhb_period_timer #(
    .TICKS_SHORT(TICKS_SHORT), .TICKS_MID(TICKS_MID), .TICKS_LONG(TICKS_LONG)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .tick_i(frame_tick), .sel_i(period_sel),
    .hold_i(desc_full), .boundary_o(boundary)
  );

  for (genvar g = 0; g < N_REG; g++) begin : g_mem
    fhb_hit_fifo #(.W(ADDR_W), .DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .push_i(push[g]), .din_i(hit_addr),
      .pop_i(pop[g]), .dout_o(head[g]), .full_o(full[g]), .empty_o(empty[g])
    );
  end

  fhb_frame_tracker #(
    .N_REG(N_REG), .QW(QW), .FID_W(FID_W), .PEND(PEND)
  ) u_track (
    .clk(clk), .rst_n(rst_n), .acc_i(push), .drop_i(drop), .boundary_i(boundary),
    .desc_full_o(desc_full), .desc_valid_o(desc_valid), .desc_fid_o(desc_fid),
    .desc_cnt_o(desc_cnt), .desc_inc_o(desc_inc), .desc_pop_i(desc_pop)
  );

  fhb_packer #(
    .N_REG(N_REG), .QW(QW), .FID_W(FID_W), .ADDR_W(ADDR_W),
    .REG_W(REG_W), .CNT_W(CNT_W), .PKT_W(PKT_W)
  ) u_pack (
    .clk(clk), .rst_n(rst_n), .desc_valid_i(desc_valid), .desc_fid_i(desc_fid),
    .desc_cnt_i(desc_cnt), .desc_inc_i(desc_inc), .desc_pop_o(desc_pop),
    .head_i(head), .pop_o(pop), .pkt_valid_o(pkt_valid), .pkt_ready_i(pkt_ready),
    .pkt_type_o(pkt_type), .pkt_data_o(pkt_data), .pkt_last_o(pkt_last)
  );

  logic unused_empty;
  assign unused_empty = ^empty;
endmodule

// File: rtl/fhb_frame_buffer_chk.sv
module fhb_frame_buffer_chk #(
  parameter int PKT_W = 18,
  parameter int CNT_W = 9,
  parameter int FID_W = 8,
  parameter int REG_W = 2,
  parameter int N_REG = 3,
  parameter int MAXC  = 384
) (
  input logic             clk,
  input logic             rst_n,
  input logic             hit_ready,
  input logic             pkt_valid,
  input logic             pkt_ready,
  input logic [1:0]       pkt_type,
  input logic [PKT_W-1:0] pkt_data,
  input logic             pkt_last
);
  logic             fire, hdr_fire, hit_fire;
  logic             fid_seen_q, reg_seen_q;
  logic [FID_W-1:0] fid_q;
  logic [REG_W-1:0] reg_q;

  assign fire     = pkt_valid && pkt_ready;
  assign hdr_fire = fire && pkt_type == 2'b00;
  assign hit_fire = fire && pkt_type == 2'b01;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fid_seen_q <= 1'b0;
      reg_seen_q <= 1'b0;
      fid_q      <= '0;
      reg_q      <= '0;
    end else begin
      if (hdr_fire) begin
        fid_seen_q <= 1'b1;
        fid_q      <= pkt_data[FID_W-1:0];
        reg_seen_q <= 1'b0;
      end
      if (hit_fire) begin
        reg_seen_q <= 1'b1;
        reg_q      <= pkt_data[PKT_W-1 -: REG_W];
      end
    end
  end

  p_in_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> hit_ready);

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && pkt_type == 2'b10) |-> (int'(pkt_data[CNT_W-1:0]) <= MAXC));

  p_kind_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |-> (pkt_type != 2'b11));

  p_last_trl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |-> (pkt_last == (pkt_type == 2'b10)));

  p_fid_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_fire && fid_seen_q) |-> (pkt_data[FID_W-1:0] == fid_q + 1'b1));

  p_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_fire && reg_seen_q) |-> (pkt_data[PKT_W-1 -: REG_W] >= reg_q));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && !pkt_ready) |=> (pkt_valid && $stable(pkt_data) && $stable(pkt_type)));

  p_region_legal_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && pkt_type == 2'b01) |-> (int'(pkt_data[PKT_W-1 -: REG_W]) < N_REG));
endmodule

bind fhb_frame_buffer fhb_frame_buffer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .hit_ready(hit_ready), .pkt_valid(pkt_valid),
  .pkt_ready(pkt_ready), .pkt_type(pkt_type), .pkt_data(pkt_data), .pkt_last(pkt_last)
);

// File: tb/test_fhb_frame_buffer.sv
module test_fhb_frame_buffer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_tick = 1'b0;
  logic [1:0]  period_sel = 2'b00;
  logic        hit_valid = 1'b0;
  logic        hit_ready;
  logic [1:0]  hit_region = '0;
  logic [14:0] hit_addr = '0;
  logic        pkt_valid;
  logic        pkt_ready = 1'b0;
  logic [1:0]  pkt_type;
  logic [17:0] pkt_data;
  logic        pkt_last;

  int checks = 0;
  int errors = 0;
  bit bp_on = 1'b0;
  int cyc = 0;

  logic [19:0] exp_q[$];
  logic [14:0] rq0[$], rq1[$], rq2[$];
  int   rcnt[3];
  bit   frame_inc = 1'b0;
  int   fid = 0;

  always #5 clk = ~clk;

  fhb_frame_buffer i_fhb_frame_buffer (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .period_sel(period_sel),
    .hit_valid(hit_valid), .hit_ready(hit_ready), .hit_region(hit_region),
    .hit_addr(hit_addr), .pkt_valid(pkt_valid), .pkt_ready(pkt_ready),
    .pkt_type(pkt_type), .pkt_data(pkt_data), .pkt_last(pkt_last)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // Driver: one hit, plus the bench-side model of acceptance (R3, R10).
  task automatic send_hit(input logic [1:0] reg_i, input logic [14:0] addr);
    @(negedge clk);
    hit_valid  = 1'b1;
    hit_region = reg_i;
    hit_addr   = addr;
    if (reg_i < 2'd3) begin
      if (rcnt[reg_i] < 128) begin
        rcnt[reg_i]++;
        case (reg_i)
          2'd0: rq0.push_back(addr);
          2'd1: rq1.push_back(addr);
          default: rq2.push_back(addr);
        endcase
      end else begin
        frame_inc = 1'b1;
      end
    end
    @(negedge clk);
    hit_valid = 1'b0;
  endtask

  task automatic wait_drain();
    int t = 0;
    while (exp_q.size() != 0 && t < 5000) begin
      @(negedge clk);
      t++;
    end
    check(exp_q.size() == 0, "R4 packet drained", exp_q.size(), 0);
  endtask

  // Push the expected packet, then issue the ticks that close the frame.
  task automatic close_frame(input int nticks, input bit wait_done);
    int total;
    total = rcnt[0] + rcnt[1] + rcnt[2];
    exp_q.push_back({2'b00, 10'd0, 8'(fid)});
    while (rq0.size() != 0) exp_q.push_back({2'b01, 2'd0, 1'b0, rq0.pop_front()});
    while (rq1.size() != 0) exp_q.push_back({2'b01, 2'd1, 1'b0, rq1.pop_front()});
    while (rq2.size() != 0) exp_q.push_back({2'b01, 2'd2, 1'b0, rq2.pop_front()});
    exp_q.push_back({2'b10, frame_inc, 8'd0, 9'(total)});
    fid = (fid + 1) % 256;
    for (int r = 0; r < 3; r++) rcnt[r] = 0;
    frame_inc = 1'b0;
    for (int i = 0; i < nticks - 1; i++) begin
      @(negedge clk);
      frame_tick = 1'b1;
    end
    @(negedge clk);
    frame_tick = 1'b0;
    if (wait_done) begin
      repeat (4) @(negedge clk);
      check(pkt_valid == 1'b0, "R2 no packet before last tick", pkt_valid, 0);
    end
    @(negedge clk);
    frame_tick = 1'b1;
    @(negedge clk);
    frame_tick = 1'b0;
    if (wait_done) wait_drain();
  endtask

  // Monitor / scoreboard.
  initial begin
    logic [19:0] want;
    logic [19:0] stall_word;
    bit          stall_prev;
    stall_prev = 1'b0;
    stall_word = '0;
    forever begin
      @(negedge clk);
      cyc++;
      if (rst_n) begin
        if (stall_prev)
          check(pkt_valid && {pkt_type, pkt_data} == stall_word, "R9 stalled word held",
                {11'd0, pkt_valid, pkt_type, pkt_data}, {12'd1, stall_word});
        pkt_ready = bp_on ? (cyc % 3 != 0) : 1'b1;
        stall_prev = pkt_valid && !pkt_ready;
        stall_word = {pkt_type, pkt_data};
        if (pkt_valid && pkt_ready) begin
          if (exp_q.size() == 0) begin
            check(1'b0, "R7 unexpected packet word", {pkt_type, pkt_data}, 0);
          end else begin
            want = exp_q.pop_front();
            case (want[19:18])
              2'b00: check({pkt_type, pkt_data} == want, "R5 header frame number",
                           {pkt_type, pkt_data}, want);
              2'b01: check({pkt_type, pkt_data} == want, "R6 hit word order",
                           {pkt_type, pkt_data}, want);
              default: begin
                check({pkt_type, pkt_data} == want, "R3 trailer count/flag",
                      {pkt_type, pkt_data}, want);
                check(pkt_last == 1'b1, "R4 last on trailer", pkt_last, 1);
              end
            endcase
          end
        end
      end
    end
  end

  initial begin
    #1_500_000ns;
    check(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    for (int r = 0; r < 3; r++) rcnt[r] = 0;
    repeat (3) @(negedge clk);
    check(pkt_valid == 1'b0, "R1 valid low in reset", pkt_valid, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(hit_ready == 1'b1, "R1 hit_ready high", hit_ready, 1);
    check(pkt_valid == 1'b0, "R1 valid low after reset", pkt_valid, 0);

    // R8: empty frame.
    close_frame(80, 1'b1);

    // R6: mixed regions, read back grouped by region.
    send_hit(2'd2, 15'h0a01);
    send_hit(2'd0, 15'h0102);
    send_hit(2'd1, 15'h7fff);
    send_hit(2'd0, 15'h0003);
    send_hit(2'd2, 15'h1234);
    close_frame(80, 1'b1);

    // R2: period codes.
    period_sel = 2'b01;
    send_hit(2'd1, 15'h0055);
    close_frame(200, 1'b1);
    period_sel = 2'b10;
    close_frame(400, 1'b1);
    period_sel = 2'b11;
    send_hit(2'd0, 15'h2222);
    close_frame(80, 1'b1);
    period_sel = 2'b00;

    // R10: out-of-range region ignored, no incomplete flag.
    send_hit(2'd3, 15'h3333);
    send_hit(2'd2, 15'h4444);
    close_frame(80, 1'b1);

    // R3: overflow of region 1.
    for (int i = 0; i < 130; i++) send_hit(2'd1, 15'(i + 16));
    send_hit(2'd0, 15'h0777);
    send_hit(2'd0, 15'h0778);
    close_frame(80, 1'b1);

    // R7 and R9: next frame's hits arrive while the previous packet drains slowly.
    bp_on = 1'b1;
    send_hit(2'd1, 15'h0101);
    send_hit(2'd0, 15'h0202);
    send_hit(2'd2, 15'h0303);
    close_frame(80, 1'b0);
    send_hit(2'd0, 15'h0a0a);
    send_hit(2'd1, 15'h0b0b);
    send_hit(2'd0, 15'h0c0c);
    close_frame(80, 1'b1);
    bp_on = 1'b0;

    // R5: frame number wraps past 255.
    while (fid != 3) close_frame(80, 1'b1);
    send_hit(2'd2, 15'h0606);
    close_frame(80, 1'b1);

    repeat (10) @(negedge clk);
    check(exp_q.size() == 0, "R4 all packets seen", exp_q.size(), 0);
    finish_run();
  end
endmodule